// File: doc/BRIEF.md
# Receive Sampling Delay Tuning Sequencer

This block searches for the best receive-sampling delay of a high-speed card interface without software stepping through the values. On a start pulse it walks a tune setting upward from zero through a fixed number of values. For each value it applies the setting to the physical layer through a self-clearing update request. It then asks an external agent to run one trial, such as a tuning-block read, and collects a pass or fail verdict for it.

While it sweeps, the block tracks the longest run of consecutive passing settings. When the sweep ends it applies the centre of that run and pulses done. If no setting passed, it raises an error instead and applies nothing. Each application of a value issues the update request twice, with a wait for the clear each time, to work around a receive-path timing weakness in the physical layer. The search only suits the 200 MHz single-data-rate eMMC mode. When started in any other mode, the block signals bypass so that a generic tuning method can take over.

Top module: `rx_tune_search`

## Requirements
- R1: After reset, upd_req_o, trial_req_o, busy_o, done_o, err_o and bypass_o are 0, and tune_val_o, sel_val_o and best_len_o are 0.
- R2: A start in the 200 MHz mode sweeps the tune values 0 to SWEEP_N-1 in strictly ascending order. It issues exactly one trial (trial_req_o held high until trial_ack_i is 1 for one cycle, with trial_pass_i sampled in that cycle) for each value whose application succeeded.
- R3: Applying a value drives it on tune_val_o and raises upd_req_o until upd_clr_i is seen. It then drops the request for at least one cycle and raises it a second time, so every successful application shows COMMIT_REPS (2) request phases.
- R4: If upd_clr_i does not arrive within UPD_TIMEOUT cycles of a request phase, the request is withdrawn, no further phase is issued for that value, no trial runs for it, and the value counts as failing.
- R5: A passing value lengthens the current run by one and a failing value resets it to zero. The best run is replaced only when the current run is strictly longer, so of two equally long runs the earlier one is kept.
- R6: After the last value, the block applies best_end - floor(best_len/2), where best_end is the last value of the best run. It uses the same double request, leaves that value on tune_val_o and reports it on sel_val_o.
- R7: If no value passed, err_o is 1 at done, best_len_o is 0 and no final application is made, so tune_val_o keeps the last swept value.
- R8: done_o is a one-cycle pulse. sel_val_o, best_len_o and err_o hold their values until the next accepted start.
- R9: A start while hs200_i is 0 produces a one-cycle bypass_o pulse and no request, trial or done.
- R10: A start while a search is in progress is ignored and does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse |
| hs200_i | input | 1 | 1 when the interface runs the 200 MHz eMMC mode |
| upd_req_o | output | 1 | Self-clearing update request to the physical layer |
| upd_clr_i | input | 1 | Physical layer reports the request bit cleared |
| tune_val_o | output | TUNE_W | Tune setting being applied |
| trial_req_o | output | 1 | Request for one trial at the current setting |
| trial_ack_i | input | 1 | Trial finished (one cycle) |
| trial_pass_i | input | 1 | Trial verdict, valid with trial_ack_i |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | Search finished (one-cycle pulse) |
| err_o | output | 1 | No passing value, or final application timed out |
| bypass_o | output | 1 | Start seen outside the 200 MHz mode (one-cycle pulse) |
| sel_val_o | output | TUNE_W | Selected setting |
| best_len_o | output | $clog2(SWEEP_N+1) | Length of the best passing run |

## Verification
The bench keeps the default tune width of 6 and the full sweep of 40 values. This lets the run-tracking reach both ends of the range: a run that ends at value 39 and a lone pass at value 0. UPD_TIMEOUT is lowered to 8 while the modelled physical layer answers after 3 cycles. With these values, a stalled update for one chosen value reaches its timeout quickly, which splits an all-pass pattern into two runs. Tie, odd-length and even-length runs, a restart attempt during a run and a start outside the 200 MHz mode are each covered by their own pass pattern.

// File: rtl/rts_pkg.sv
package rts_pkg;
  typedef enum logic [1:0] {
    CM_IDLE,
    CM_REQ,
    CM_GAP
  } cm_state_e;

  typedef enum logic [2:0] {
    TS_IDLE,
    TS_COMMIT,
    TS_TRIAL,
    TS_NEXT,
    TS_EVAL,
    TS_FINAL
  } ts_state_e;
endpackage

// File: rtl/rts_commit.sv
module rts_commit
  import rts_pkg::*;
#(
  parameter int TUNE_W      = 6,
  parameter int UPD_TIMEOUT = 64,
  parameter int COMMIT_REPS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_i,
  input  logic [TUNE_W-1:0] val_i,
  input  logic              upd_clr_i,
  output logic              upd_req_o,
  output logic [TUNE_W-1:0] tune_o,
  output logic              done_o,
  output logic              ok_o
);
  localparam int TMO_W = $clog2(UPD_TIMEOUT + 1);
  localparam int REP_W = $clog2(COMMIT_REPS + 1);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(UPD_TIMEOUT - 1);
  localparam logic [REP_W-1:0] REP_LAST = REP_W'(COMMIT_REPS - 1);

  cm_state_e        st;
  logic [TMO_W-1:0] wait_cnt;
  logic [REP_W-1:0] rep;
  logic             tmo;

  assign tmo = (wait_cnt == TMO_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= CM_IDLE;
      upd_req_o <= 1'b0;
      tune_o    <= '0;
      wait_cnt  <= '0;
      rep       <= '0;
      done_o    <= 1'b0;
      ok_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      ok_o   <= 1'b0;
      case (st)
        CM_IDLE: begin
          if (go_i) begin
            tune_o    <= val_i;
            upd_req_o <= 1'b1;
            wait_cnt  <= '0;
            rep       <= '0;
            st        <= CM_REQ;
          end
        end
        CM_REQ: begin
          if (upd_clr_i) begin
            upd_req_o <= 1'b0;
            if (rep == REP_LAST) begin
              done_o <= 1'b1;
              ok_o   <= 1'b1;
              st     <= CM_IDLE;
            end else begin
              rep <= rep + 1'b1;
              st  <= CM_GAP;
            end
          end else if (tmo) begin
            upd_req_o <= 1'b0;
            done_o    <= 1'b1;
            st        <= CM_IDLE;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        CM_GAP: begin
          upd_req_o <= 1'b1;
          wait_cnt  <= '0;
          st        <= CM_REQ;
        end
        default: st <= CM_IDLE;
      endcase
    end
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == CM_REQ && !upd_clr_i && !tmo) |=> upd_req_o);

  // R4
  tmo_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (st == CM_REQ && !upd_clr_i && tmo) |=> (!upd_req_o && done_o && !ok_o));

  // R3
  ok_after_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ok_o |-> ($past(upd_clr_i) && !upd_req_o));
endmodule

// File: rtl/rts_window.sv
module rts_window #(
  parameter int TUNE_W = 6,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic              step_i,
  input  logic              pass_i,
  input  logic [TUNE_W-1:0] idx_i,
  output logic [LEN_W-1:0]  best_len_o,
  output logic [TUNE_W-1:0] best_end_o
);
  logic [LEN_W-1:0] cur_len;
  logic [LEN_W-1:0] cur_next;

  assign cur_next = cur_len + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      cur_len    <= '0;
      best_len_o <= '0;
      best_end_o <= '0;
    end else if (step_i) begin
      if (pass_i) begin
        cur_len <= cur_next;
        if (cur_next > best_len_o) begin
          best_len_o <= cur_next;
          best_end_o <= idx_i;
        end
      end else begin
        cur_len <= '0;
      end
    end
  end

  // R5
  run_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cur_len <= best_len_o);

  // R5
  best_mono_chk: assert property (@(posedge clk) disable iff (rst)
    !clear_i |=> best_len_o >= $past(best_len_o));

  // R5
  fail_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i && !pass_i && !clear_i) |=> cur_len == '0);
endmodule

// File: rtl/rx_tune_search.sv
module rx_tune_search
  import rts_pkg::*;
#(
  parameter int TUNE_W      = 6,
  parameter int SWEEP_N     = 40,
  parameter int UPD_TIMEOUT = 64,
  parameter int COMMIT_REPS = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start_i,
  input  logic                         hs200_i,
  output logic                         upd_req_o,
  input  logic                         upd_clr_i,
  output logic [TUNE_W-1:0]            tune_val_o,
  output logic                         trial_req_o,
  input  logic                         trial_ack_i,
  input  logic                         trial_pass_i,
  output logic                         busy_o,
  output logic                         done_o,
  output logic                         err_o,
  output logic                         bypass_o,
  output logic [TUNE_W-1:0]            sel_val_o,
  output logic [$clog2(SWEEP_N+1)-1:0] best_len_o
);
  localparam int LEN_W = $clog2(SWEEP_N + 1);
  localparam logic [TUNE_W-1:0] LAST = TUNE_W'(SWEEP_N - 1);

  ts_state_e         st;
  logic [TUNE_W-1:0] idx;
  logic              c_go;
  logic [TUNE_W-1:0] c_val;
  logic              c_done;
  logic              c_ok;
  logic              w_clear;
  logic              w_step;
  logic              w_pass;
  logic [TUNE_W-1:0] best_end;
  logic [TUNE_W-1:0] fin_val;
  logic              accept;

  assign accept  = (st == TS_IDLE) && start_i && hs200_i;
  assign w_clear = accept;
  assign w_step  = ((st == TS_COMMIT) && c_done && !c_ok) ||
                   ((st == TS_TRIAL) && trial_ack_i);
  assign w_pass  = (st == TS_TRIAL) && trial_pass_i;
  assign fin_val = best_end - TUNE_W'(best_len_o >> 1);

  always_comb begin
    c_go  = 1'b0;
    c_val = '0;
    case (st)
      TS_IDLE: begin
        c_go  = accept;
        c_val = '0;
      end
      TS_NEXT: begin
        c_go  = (idx != LAST);
        c_val = idx + 1'b1;
      end
      TS_EVAL: begin
        c_go  = (best_len_o != '0);
        c_val = fin_val;
      end
      default: begin
        c_go  = 1'b0;
        c_val = '0;
      end
    endcase
  end

  rts_commit #(
    .TUNE_W     (TUNE_W),
    .UPD_TIMEOUT(UPD_TIMEOUT),
    .COMMIT_REPS(COMMIT_REPS)
  ) u_commit (
    .clk      (clk),
    .rst      (rst),
    .go_i     (c_go),
    .val_i    (c_val),
    .upd_clr_i(upd_clr_i),
    .upd_req_o(upd_req_o),
    .tune_o   (tune_val_o),
    .done_o   (c_done),
    .ok_o     (c_ok)
  );

  rts_window #(
    .TUNE_W(TUNE_W),
    .LEN_W (LEN_W)
  ) u_window (
    .clk       (clk),
    .rst       (rst),
    .clear_i   (w_clear),
    .step_i    (w_step),
    .pass_i    (w_pass),
    .idx_i     (idx),
    .best_len_o(best_len_o),
    .best_end_o(best_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= TS_IDLE;
      idx         <= '0;
      trial_req_o <= 1'b0;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
      bypass_o    <= 1'b0;
      sel_val_o   <= '0;
    end else begin
      done_o   <= 1'b0;
      bypass_o <= 1'b0;
      case (st)
        TS_IDLE: begin
          if (start_i && !hs200_i) begin
            bypass_o <= 1'b1;
          end else if (accept) begin
            busy_o    <= 1'b1;
            idx       <= '0;
            err_o     <= 1'b0;
            sel_val_o <= '0;
            st        <= TS_COMMIT;
          end
        end
        TS_COMMIT: begin
          if (c_done) begin
            if (c_ok) begin
              trial_req_o <= 1'b1;
              st          <= TS_TRIAL;
            end else begin
              st <= TS_NEXT;
            end
          end
        end
        TS_TRIAL: begin
          if (trial_ack_i) begin
            trial_req_o <= 1'b0;
            st          <= TS_NEXT;
          end
        end
        TS_NEXT: begin
          if (idx == LAST) begin
            st <= TS_EVAL;
          end else begin
            idx <= idx + 1'b1;
            st  <= TS_COMMIT;
          end
        end
        TS_EVAL: begin
          if (best_len_o == '0) begin
            err_o  <= 1'b1;
            done_o <= 1'b1;
            busy_o <= 1'b0;
            st     <= TS_IDLE;
          end else begin
            sel_val_o <= fin_val;
            st        <= TS_FINAL;
          end
        end
        TS_FINAL: begin
          if (c_done) begin
            err_o  <= !c_ok;
            done_o <= 1'b1;
            busy_o <= 1'b0;
            st     <= TS_IDLE;
          end
        end
        default: st <= TS_IDLE;
      endcase
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R6
  final_on_bus_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !err_o) |-> (tune_val_o == sel_val_o));

  // R7
  no_pass_err_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && best_len_o == '0) |-> err_o);

  // R9
  bypass_idle_chk: assert property (@(posedge clk) disable iff (rst)
    bypass_o |-> (!busy_o && !trial_req_o && !upd_req_o));

  // R2
  trial_excl_chk: assert property (@(posedge clk) disable iff (rst)
    trial_req_o |-> (busy_o && !upd_req_o));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !$past(busy_o)) |-> $stable(sel_val_o));
endmodule

// File: tb/rx_tune_search_tb.sv
module rx_tune_search_tb;
  localparam int TUNE_W  = 6;
  localparam int SWEEP_N = 40;
  localparam int TMO     = 8;
  localparam int PHY_DLY = 3;
  localparam int LEN_W   = $clog2(SWEEP_N + 1);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_i = 1'b0;
  logic              hs200_i = 1'b1;
  logic              upd_req_o;
  logic              upd_clr_i = 1'b0;
  logic [TUNE_W-1:0] tune_val_o;
  logic              trial_req_o;
  logic              trial_ack_i = 1'b0;
  logic              trial_pass_i = 1'b0;
  logic              busy_o, done_o, err_o, bypass_o;
  logic [TUNE_W-1:0] sel_val_o;
  logic [LEN_W-1:0]  best_len_o;

  always #10 clk = ~clk;

  rx_tune_search #(
    .TUNE_W(TUNE_W), .SWEEP_N(SWEEP_N), .UPD_TIMEOUT(TMO), .COMMIT_REPS(2)
  ) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .hs200_i(hs200_i),
    .upd_req_o(upd_req_o), .upd_clr_i(upd_clr_i), .tune_val_o(tune_val_o),
    .trial_req_o(trial_req_o), .trial_ack_i(trial_ack_i), .trial_pass_i(trial_pass_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .bypass_o(bypass_o),
    .sel_val_o(sel_val_o), .best_len_o(best_len_o)
  );

  typedef struct {
    int sel; int len; int err; int rises; int trials; int tv; string name;
  } exp_t;

  exp_t   sb_q[$];
  int     n_chk = 0;
  int     n_bad = 0;
  logic [63:0] pass_mask = '0;
  int     stall_val = 63;
  int     rise_cnt = 0;
  int     trial_cnt = 0;
  int     run_no = 0;
  int     done_seen = 0;

  task automatic check(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // PHY model: clears each request after PHY_DLY cycles, never for stall_val
  initial begin
    forever begin
      @(negedge clk);
      if (upd_req_o) begin
        rise_cnt++;
        if (int'(tune_val_o) == stall_val) begin
          while (upd_req_o) @(negedge clk);
        end else begin
          repeat (PHY_DLY - 1) @(negedge clk);
          upd_clr_i = 1'b1;
          @(negedge clk);
          upd_clr_i = 1'b0;
          while (upd_req_o) @(negedge clk);
        end
      end
    end
  end

  // trial agent: checks ascending order (R2), answers from pass_mask
  initial begin
    int seen_run = 0;
    int prev = -1;
    forever begin
      @(negedge clk);
      if (trial_req_o) begin
        trial_cnt++;
        if (seen_run != run_no) begin
          seen_run = run_no;
          prev = -1;
        end
        if (int'(tune_val_o) <= prev) check("R2 order", int'(tune_val_o), prev + 1);
        prev = int'(tune_val_o);
        repeat (1) @(negedge clk);
        trial_ack_i  = 1'b1;
        trial_pass_i = pass_mask[tune_val_o];
        @(negedge clk);
        trial_ack_i  = 1'b0;
        trial_pass_i = 1'b0;
      end
    end
  end

  // monitor: pops the scoreboard on every done pulse
  initial begin
    forever begin
      @(negedge clk);
      if (done_o) begin
        exp_t e;
        done_seen++;
        if (sb_q.size() == 0) begin
          check("R8 unexpected done", 1, 0);
        end else begin
          e = sb_q.pop_front();
          check({"R5 best_len ", e.name}, int'(best_len_o), e.len);
          check({"R7 err ", e.name}, int'(err_o), e.err);
          if (e.err == 0) check({"R6 sel ", e.name}, int'(sel_val_o), e.sel);
          check({"R3 request phases ", e.name}, rise_cnt, e.rises);
          check({"R2 trials ", e.name}, trial_cnt, e.trials);
          check({"R6 tune_val ", e.name}, int'(tune_val_o), e.tv);
        end
      end
    end
  end

  task automatic run_case(input string name, input logic [63:0] mask,
                          input int stall, input bit poke_restart);
    exp_t e;
    int cur = 0, best = 0, bend = 0, rises = 0, trials = 0;
    for (int i = 0; i < SWEEP_N; i++) begin
      bit ok;
      ok = (i != stall);
      rises += ok ? 2 : 1;
      if (ok) trials++;
      if (ok && mask[i]) begin
        cur++;
        if (cur > best) begin best = cur; bend = i; end
      end else cur = 0;
    end
    e.name = name; e.len = best; e.err = (best == 0);
    e.sel = bend - best / 2;
    e.rises = rises + (best > 0 ? 2 : 0);
    e.trials = trials;
    e.tv = (best > 0) ? e.sel : SWEEP_N - 1;
    pass_mask = mask; stall_val = stall;
    rise_cnt = 0; trial_cnt = 0; run_no++;
    sb_q.push_back(e);
    @(negedge clk); start_i = 1'b1; hs200_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    if (poke_restart) begin
      repeat (60) @(negedge clk);
      start_i = 1'b1;            // R10: ignored while busy
      @(negedge clk); start_i = 1'b0;
    end
    begin
      int d0 = done_seen;
      while (done_seen == d0) @(negedge clk);
    end
    repeat (5) @(negedge clk);
    check({"R8 sel held ", name}, int'(sel_val_o), best > 0 ? e.sel : 0);
    check({"R8 len held ", name}, int'(best_len_o), best);
    check({"R8 done one cycle ", name}, int'(done_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check("R1 reset outputs", int'({upd_req_o, trial_req_o, busy_o, done_o, err_o, bypass_o}), 0);
    check("R1 reset values", int'(tune_val_o) + int'(sel_val_o) + int'(best_len_o), 0);

    run_case("all pass R10", (64'd1 << SWEEP_N) - 1, 63, 1'b1);
    run_case("window 10..17", 64'h3FC00, 63, 1'b0);
    run_case("tie R5", 64'hF0003C, 63, 1'b0);
    run_case("longer later", 64'hFFC0000007, 63, 1'b0);
    run_case("none R7", 64'h0, 63, 1'b0);
    run_case("lone zero", 64'h1, 63, 1'b0);
    run_case("stall R4", (64'd1 << SWEEP_N) - 1, 7, 1'b0);
    run_case("odd 5..7", 64'hE0, 63, 1'b0);

    // R9: start outside the 200 MHz mode
    rise_cnt = 0; trial_cnt = 0;
    @(negedge clk); start_i = 1'b1; hs200_i = 1'b0;
    @(negedge clk); start_i = 1'b0;
    check("R9 bypass pulse", int'(bypass_o), 1);
    @(negedge clk);
    check("R9 bypass one cycle", int'(bypass_o), 0);
    repeat (20) @(negedge clk);
    check("R9 no activity", rise_cnt + trial_cnt + int'(busy_o), 0);
    check("R9 no done", int'(sb_q.size()), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule